// File: doc/BRIEF.md
# Key-Locked System Control Register Bank

This block is a bank of 32-bit configuration and status words that fills a 4 KB byte-addressed window. Software reaches it through a simple register bus: one byte address, a write strobe with write data, and a read strobe. Registered read data appears in the cycle after the read strobe. Bits [1:0] of the address are ignored, so each word sits at the byte offset divided by four.

A write-protect lock guards every ordinary read/write word, and the lock comes out of reset engaged. Two key ports change the lock. The engage port accepts 0x767B in the low 16 data bits. The release port accepts 0xDF0D in the low 16 data bits. Any other value written to either port changes nothing. Every offset belongs to one of four access classes: read/write, read-only, write-only or unmapped. A strobe that breaks its class raises an error pulse and leaves all state alone. When software sets bit 0 of the reset-control word while the bank is unlocked, the bank requests a system soft reset with a single-cycle pulse. The words only hold values and have no side effects of their own.

Read/write map, with reset values: scratch flag 0x000 (only bit 0 is kept, reset 0), three PLL words 0x100..0x108 (0x0001A008), reset-control 0x200 (0), reset-reason 0x250 (0x00000040), and NUM_PIN pin-config words from 0x700 (0x00001601; pins 2..8 reset to 0x00000601). Read-only: lock status 0x00C (1 = locked), PLL status 0x10C (0x0000003F), boot mode 0x25C (0x00000001), ID 0x530 (the ID_CODE parameter). Write-only: engage key 0x004, release key 0x008, calibration start 0x60C, refresh start 0x614. Every other offset is unmapped.

Top module: `syscfg_keylock_bank`

## Requirements
- R1: After reset the lock status reads 1, and every word reads its reset value from the map above. acc_err_o and soft_rst_req_o are low.
- R2: Read data is registered. rd_data_o takes the addressed value in the cycle after rd_en_i and holds it while no read strobe occurs. A read in the same cycle as a write returns the value from before the write.
- R3: A write to 0x004 whose data bits [15:0] equal 0x767B sets the lock status to 1. Any other data leaves the lock unchanged.
- R4: A write to 0x008 whose data bits [15:0] equal 0xDF0D clears the lock status to 0. Bits [31:16] are ignored, and any other low half leaves the lock unchanged.
- R5: While locked, writes to read/write words are discarded without an error. The key ports at 0x004 and 0x008 stay writable at all times.
- R6: The word at 0x000 keeps only bit 0 of written data, and bits [31:1] read 0.
- R7: Write-only offsets (0x004, 0x008, 0x60C, 0x614) read as 0 and raise an error when read. Writes to 0x60C and 0x614 are accepted with no error and no effect.
- R8: A write to a read-only offset (0x00C, 0x10C, 0x25C, 0x530) raises an error and does not change the value read there.
- R9: A write to an unmapped offset (for example 0x800, or 0x7D8 just past the last pin word) raises an error and changes no state. A read of an unmapped offset returns 0 with an error.
- R10: An unlocked write to 0x200 with data bit 0 set stores the data and pulses soft_rst_req_o high for exactly the next cycle. No pulse occurs when bit 0 is clear or when the bank is locked.
- R11: acc_err_o is high exactly in the cycle after an illegal strobe and low otherwise.
- R12: Address bits [1:0] are ignored for both reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_i | input | 12 | Byte address within the window |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 32 | Registered read data |
| acc_err_o | output | 1 | One-cycle illegal-access pulse |
| soft_rst_req_o | output | 1 | One-cycle soft-reset request |

## Verification
The hardest case to reach from the ports is a reset-control write that arrives while the bank is locked. It needs the bank released with the correct key, a reset-control write that fires, a bad engage key that must have no effect, and then a correct engage key before the reset-control write is repeated. The stimulus runs that chain in order, with bad keys placed between the good ones, and checks the pulse and the stored word at each step. A behavioural model with its own address map predicts the outputs on every clock. Directed reads probe the ends of the pin region and the key ports.

// File: rtl/kb_pkg.sv
package kb_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned IDX_W  = ADDR_W - 2;
  localparam int unsigned DATA_W = 32;

  typedef enum logic [1:0] {ACC_NONE, ACC_RW, ACC_RO, ACC_WO} acc_e;

  // word indices (byte offset / 4)
  localparam logic [IDX_W-1:0] W_SCRATCH = 10'h000;
  localparam logic [IDX_W-1:0] W_LOCK    = 10'h001;
  localparam logic [IDX_W-1:0] W_UNLOCK  = 10'h002;
  localparam logic [IDX_W-1:0] W_LSTAT   = 10'h003;
  localparam logic [IDX_W-1:0] W_PLL0    = 10'h040;
  localparam logic [IDX_W-1:0] W_PLLST   = 10'h043;
  localparam logic [IDX_W-1:0] W_RSTCTL  = 10'h080;
  localparam logic [IDX_W-1:0] W_REASON  = 10'h094;
  localparam logic [IDX_W-1:0] W_BOOT    = 10'h097;
  localparam logic [IDX_W-1:0] W_ID      = 10'h14C;
  localparam logic [IDX_W-1:0] W_CAL     = 10'h183;
  localparam logic [IDX_W-1:0] W_REF     = 10'h185;
  localparam logic [IDX_W-1:0] W_PIN0    = 10'h1C0;

  localparam int unsigned NUM_PLL = 3;

  localparam logic [15:0] KEY_ENGAGE  = 16'h767B;
  localparam logic [15:0] KEY_RELEASE = 16'hDF0D;

  localparam logic [DATA_W-1:0] PLL_RV     = 32'h0001_A008;
  localparam logic [DATA_W-1:0] PLLST_RV   = 32'h0000_003F;
  localparam logic [DATA_W-1:0] BOOT_RV    = 32'h0000_0001;
  localparam logic [DATA_W-1:0] REASON_RV  = 32'h0000_0040;
  localparam logic [DATA_W-1:0] PIN_RV     = 32'h0000_1601;
  localparam logic [DATA_W-1:0] PIN_ALT_RV = 32'h0000_0601;
  localparam int unsigned PIN_ALT_LO = 2;
  localparam int unsigned PIN_ALT_HI = 8;

  // storage slot layout
  localparam int unsigned SLOT_SCRATCH = 0;
  localparam int unsigned SLOT_PLL     = 1;
  localparam int unsigned SLOT_RST     = SLOT_PLL + NUM_PLL;
  localparam int unsigned SLOT_REASON  = SLOT_RST + 1;
  localparam int unsigned SLOT_PIN     = SLOT_REASON + 1;
endpackage

// File: rtl/kb_rst_sync.sv
module kb_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/kb_decode.sv
module kb_decode import kb_pkg::*; #(
  parameter int unsigned NUM_PIN = 54,
  parameter int unsigned SLOT_W  = 6
) (
  input  logic [IDX_W-1:0]  word_i,
  output acc_e              cls_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              is_lock_o,
  output logic              is_unlock_o,
  output logic              is_rstctl_o
);
  localparam logic [IDX_W-1:0] PLL_N = IDX_W'(NUM_PLL);
  localparam logic [IDX_W:0]   PIN_N = (IDX_W+1)'(NUM_PIN);

  logic [IDX_W-1:0] pll_off;
  logic [IDX_W:0]   pin_off;

  always_comb begin
    cls_o       = ACC_NONE;
    slot_o      = '0;
    is_lock_o   = 1'b0;
    is_unlock_o = 1'b0;
    is_rstctl_o = 1'b0;
    pll_off     = word_i - W_PLL0;
    pin_off     = {1'b0, word_i} - {1'b0, W_PIN0};
    if (word_i == W_SCRATCH) begin
      cls_o  = ACC_RW;
      slot_o = SLOT_W'(SLOT_SCRATCH);
    end else if (word_i == W_LOCK) begin
      cls_o     = ACC_WO;
      is_lock_o = 1'b1;
    end else if (word_i == W_UNLOCK) begin
      cls_o       = ACC_WO;
      is_unlock_o = 1'b1;
    end else if (word_i >= W_PLL0 && pll_off < PLL_N) begin
      cls_o  = ACC_RW;
      slot_o = SLOT_W'(SLOT_PLL) + SLOT_W'(pll_off);
    end else if (word_i == W_RSTCTL) begin
      cls_o       = ACC_RW;
      slot_o      = SLOT_W'(SLOT_RST);
      is_rstctl_o = 1'b1;
    end else if (word_i == W_REASON) begin
      cls_o  = ACC_RW;
      slot_o = SLOT_W'(SLOT_REASON);
    end else if (word_i >= W_PIN0 && pin_off < PIN_N) begin
      cls_o  = ACC_RW;
      slot_o = SLOT_W'(SLOT_PIN) + SLOT_W'(pin_off);
    end else if (word_i == W_LSTAT || word_i == W_PLLST ||
                 word_i == W_BOOT  || word_i == W_ID) begin
      cls_o = ACC_RO;
    end else if (word_i == W_CAL || word_i == W_REF) begin
      cls_o = ACC_WO;
    end
  end
endmodule

// File: rtl/kb_lock.sv
module kb_lock import kb_pkg::*; (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        engage_wr_i,
  input  logic        release_wr_i,
  input  logic [15:0] key_i,
  output logic        locked_o
);
  logic lock_d;
  logic lock_q;

  always_comb begin
    lock_d = lock_q;
    if (engage_wr_i && key_i == KEY_ENGAGE)   lock_d = 1'b1;
    if (release_wr_i && key_i == KEY_RELEASE) lock_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lock_q <= 1'b1;
    else         lock_q <= lock_d;
  end

  assign locked_o = lock_q;
endmodule

// File: rtl/kb_store.sv
module kb_store import kb_pkg::*; #(
  parameter int unsigned NUM_PIN   = 54,
  parameter int unsigned NUM_SLOTS = SLOT_PIN + NUM_PIN,
  parameter int unsigned SLOT_W    = 6
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             we_i,
  input  logic [SLOT_W-1:0]                slot_i,
  input  logic [DATA_W-1:0]                wdata_i,
  output logic [NUM_SLOTS-1:0][DATA_W-1:0] q_o
);
  function automatic logic [DATA_W-1:0] rst_val(int unsigned i);
    if (i >= SLOT_PLL && i < SLOT_PLL + NUM_PLL) return PLL_RV;
    if (i == SLOT_REASON) return REASON_RV;
    if (i >= SLOT_PIN) begin
      if (i - SLOT_PIN >= PIN_ALT_LO && i - SLOT_PIN <= PIN_ALT_HI) return PIN_ALT_RV;
      return PIN_RV;
    end
    return '0;
  endfunction

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    localparam logic [DATA_W-1:0] RV = rst_val(i);
    logic hit;
    assign hit = we_i && (slot_i == SLOT_W'(i));
    if (i == SLOT_SCRATCH) begin : g_flag
      logic flag_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  flag_q <= RV[0];
        else if (hit) flag_q <= wdata_i[0];
      end
      assign q_o[i] = {{(DATA_W-1){1'b0}}, flag_q};
    end else begin : g_word
      logic [DATA_W-1:0] word_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  word_q <= RV;
        else if (hit) word_q <= wdata_i;
      end
      assign q_o[i] = word_q;
    end
  end
endmodule

// File: rtl/syscfg_keylock_bank.sv
module syscfg_keylock_bank import kb_pkg::*; #(
  parameter int unsigned       NUM_PIN = 54,
  parameter logic [DATA_W-1:0] ID_CODE = 32'h0A5C_1001
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              acc_err_o,
  output logic              soft_rst_req_o
);
  localparam int unsigned NUM_SLOTS = SLOT_PIN + NUM_PIN;
  localparam int unsigned SLOT_W    = $clog2(NUM_SLOTS);

  logic                             rst_n_s;
  logic [IDX_W-1:0]                 word;
  logic [1:0]                       unused_lo;
  acc_e                             dec_cls;
  logic [SLOT_W-1:0]                dec_slot;
  logic                             dec_lock, dec_unlock, dec_rstctl;
  logic                             lock_q;
  logic                             store_we;
  logic [NUM_SLOTS-1:0][DATA_W-1:0] slot_q;
  logic [DATA_W-1:0]                rd_val;
  logic [DATA_W-1:0]                rdata_d, rdata_q;
  logic                             err_d, err_q;
  logic                             rreq_d, rreq_q;
  logic                             wr_bad, rd_bad;

  assign word      = addr_i[ADDR_W-1:2];
  assign unused_lo = addr_i[1:0];

  kb_rst_sync u_rst_sync (.clk_i(clk_i), .rst_ni(rst_ni), .rst_no(rst_n_s));

  kb_decode #(.NUM_PIN(NUM_PIN), .SLOT_W(SLOT_W)) u_decode (
    .word_i(word), .cls_o(dec_cls), .slot_o(dec_slot),
    .is_lock_o(dec_lock), .is_unlock_o(dec_unlock), .is_rstctl_o(dec_rstctl)
  );

  kb_lock u_lock (
    .clk_i(clk_i), .rst_ni(rst_n_s),
    .engage_wr_i(wr_en_i && dec_lock), .release_wr_i(wr_en_i && dec_unlock),
    .key_i(wr_data_i[15:0]), .locked_o(lock_q)
  );

  assign store_we = wr_en_i && dec_cls == ACC_RW && !lock_q;

  kb_store #(.NUM_PIN(NUM_PIN), .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_store (
    .clk_i(clk_i), .rst_ni(rst_n_s), .we_i(store_we), .slot_i(dec_slot),
    .wdata_i(wr_data_i), .q_o(slot_q)
  );

  always_comb begin
    case (dec_cls)
      ACC_RW: rd_val = slot_q[dec_slot];
      ACC_RO: begin
        if (word == W_LSTAT)      rd_val = {{(DATA_W-1){1'b0}}, lock_q};
        else if (word == W_PLLST) rd_val = PLLST_RV;
        else if (word == W_BOOT)  rd_val = BOOT_RV;
        else                      rd_val = ID_CODE;
      end
      default: rd_val = '0;
    endcase
  end

  always_comb begin
    wr_bad  = wr_en_i && (dec_cls == ACC_NONE || dec_cls == ACC_RO);
    rd_bad  = rd_en_i && (dec_cls == ACC_NONE || dec_cls == ACC_WO);
    err_d   = wr_bad || rd_bad;
    rreq_d  = wr_en_i && dec_rstctl && !lock_q && wr_data_i[0];
    rdata_d = rd_val;
  end

  always_ff @(posedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
      rreq_q  <= 1'b0;
    end else begin
      if (rd_en_i) rdata_q <= rdata_d;
      err_q  <= err_d;
      rreq_q <= rreq_d;
    end
  end

  assign rd_data_o      = rdata_q;
  assign acc_err_o      = err_q;
  assign soft_rst_req_o = rreq_q;
endmodule

// File: rtl/kb_chk.sv
module kb_chk import kb_pkg::*; (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              rd_en_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              acc_err_o,
  input logic              soft_rst_req_o,
  input logic              locked_i
);
  logic [IDX_W-1:0] w;
  logic [1:0]       unused_lo;
  assign w         = addr_i[ADDR_W-1:2];
  assign unused_lo = addr_i[1:0];

  // R3
  lock_engage_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_i) |-> $past(wr_en_i && w == W_LOCK && wr_data_i[15:0] == KEY_ENGAGE));

  // R4
  lock_release_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(locked_i) |-> $past(wr_en_i && w == W_UNLOCK && wr_data_i[15:0] == KEY_RELEASE));

  // R10
  soft_rst_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_req_o |-> $past(wr_en_i && w == W_RSTCTL && wr_data_i[0] && !locked_i));

  // R11
  err_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_err_o |-> $past(wr_en_i || rd_en_i));

  // R7
  wo_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && (w == W_LOCK || w == W_UNLOCK || w == W_CAL || w == W_REF))
    |=> (rd_data_o == '0 && acc_err_o));

  // R8
  ro_write_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (w == W_LSTAT || w == W_PLLST || w == W_BOOT || w == W_ID)) |=> acc_err_o);

  // R2
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));
endmodule

bind syscfg_keylock_bank kb_chk u_kb_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_en_i(wr_en_i),
  .wr_data_i(wr_data_i), .rd_en_i(rd_en_i), .rd_data_o(rd_data_o),
  .acc_err_o(acc_err_o), .soft_rst_req_o(soft_rst_req_o), .locked_i(lock_q)
);

// File: tb/syscfg_keylock_bank_tb_top.sv
`timescale 1ns/1ps
module syscfg_keylock_bank_tb_top;
  localparam logic [31:0] ID = 32'h0A5C_1001;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic        acc_err;
  logic        soft_rst;

  int n_run = 0;
  int n_fail = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  syscfg_keylock_bank #(.NUM_PIN(54), .ID_CODE(ID)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .wr_data_i(wdata), .rd_en_i(rd_en), .rd_data_o(rd_data),
    .acc_err_o(acc_err), .soft_rst_req_o(soft_rst)
  );

  // ---------------- behavioural reference model ----------------
  int unsigned mmem [int];
  bit          mlock;
  logic [31:0] e_rdata;
  bit          e_err, e_rst;

  // 0 unmapped, 1 read/write, 2 read-only, 3 write-only
  function automatic int cls(int w);
    if (w == 0 || (w >= 'h40 && w <= 'h42) || w == 'h80 || w == 'h94 ||
        (w >= 'h1C0 && w < 'h1C0 + 54)) return 1;
    if (w == 3 || w == 'h43 || w == 'h97 || w == 'h14C) return 2;
    if (w == 1 || w == 2 || w == 'h183 || w == 'h185) return 3;
    return 0;
  endfunction

  function automatic logic [31:0] mread(int w);
    if (w == 3)     return {31'd0, mlock};
    if (w == 'h43)  return 32'h3F;
    if (w == 'h97)  return 32'h1;
    if (w == 'h14C) return ID;
    if (mmem.exists(w)) return mmem[w];
    return 32'h0;
  endfunction

  task automatic model_reset();
    mmem.delete();
    for (int i = 'h40; i <= 'h42; i++) mmem[i] = 32'h0001_A008;
    mmem['h94] = 32'h40;
    for (int p = 0; p < 54; p++) mmem['h1C0 + p] = (p >= 2 && p <= 8) ? 32'h601 : 32'h1601;
    mlock = 1'b1; e_rdata = '0; e_err = 1'b0; e_rst = 1'b0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else begin
      int w, c;
      bit n_err, n_rst;
      w = int'(addr[11:2]); c = cls(w); n_err = 0; n_rst = 0;
      if (rd_en) begin
        e_rdata = (c == 1 || c == 2) ? mread(w) : 32'h0;
        if (c == 0 || c == 3) n_err = 1;
      end
      if (wr_en) begin
        if (c == 0 || c == 2) n_err = 1;
        else if (w == 1) begin if (wdata[15:0] == 16'h767B) mlock = 1; end
        else if (w == 2) begin if (wdata[15:0] == 16'hDF0D) mlock = 0; end
        else if (c == 1 && !mlock) begin
          mmem[w] = (w == 0) ? (wdata & 32'h1) : wdata;
          if (w == 'h80 && wdata[0]) n_rst = 1;
        end
      end
      e_err = n_err; e_rst = n_rst;
    end
  end

  always @(negedge clk) begin
    if (cmp_on && rst_n && !done) begin
      n_run++;
      if (rd_data !== e_rdata || acc_err !== e_err || soft_rst !== e_rst) begin
        n_fail++;
        $display("FAIL R2/R11/R10 model: rdata %h exp %h, err %b exp %b, rst %b exp %b",
                 rd_data, e_rdata, acc_err, e_err, soft_rst, e_rst);
      end
    end
  end

  // ---------------- directed stimulus ----------------
  bit last_err, last_rst, next_rst;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; last_err = acc_err; last_rst = soft_rst;
    @(negedge clk); next_rst = soft_rst;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rd_data; last_err = acc_err;
  endtask

  task automatic finish_up();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 err idle", {31'd0, acc_err}, 0);
    chk("R1 rst idle", {31'd0, soft_rst}, 0);
    cmp_on = 1'b1;

    // R1 reset values
    rd(12'h00C, v); chk("R1 lock status", v, 1);
    chk("R1 legal read no err", {31'd0, last_err}, 0);
    rd(12'h104, v); chk("R1 pll word", v, 32'h0001_A008);
    rd(12'h10C, v); chk("R1 pll status", v, 32'h3F);
    rd(12'h25C, v); chk("R1 boot mode", v, 1);
    rd(12'h250, v); chk("R1 reset reason", v, 32'h40);
    rd(12'h700, v); chk("R1 pin0", v, 32'h1601);
    rd(12'h708, v); chk("R1 pin2", v, 32'h601);
    rd(12'h720, v); chk("R1 pin8", v, 32'h601);
    rd(12'h724, v); chk("R1 pin9", v, 32'h1601);
    rd(12'h200, v); chk("R1 reset ctl", v, 0);
    rd(12'h530, v); chk("R1 id", v, ID);

    // R5 locked write discarded
    wr(12'h100, 32'h1234_5678);
    chk("R5 locked write no err", {31'd0, last_err}, 0);
    rd(12'h100, v); chk("R5 locked write discarded", v, 32'h0001_A008);

    // R4 wrong then right release key
    wr(12'h008, 32'h0000_DF0E);
    rd(12'h00C, v); chk("R4 bad release key ignored", v, 1);
    wr(12'h008, 32'hABCD_DF0D);
    chk("R5 release key no err", {31'd0, last_err}, 0);
    rd(12'h00C, v); chk("R4 released", v, 0);

    // R2 store and readback, hold without strobe
    wr(12'h100, 32'hCAFE_F00D);
    rd(12'h100, v); chk("R2 readback", v, 32'hCAFE_F00D);
    repeat (3) @(negedge clk);
    chk("R2 read data held", rd_data, 32'hCAFE_F00D);

    // R6 scratch flag
    wr(12'h000, 32'hFFFF_FFFE);
    rd(12'h000, v); chk("R6 bit0 clear", v, 0);
    wr(12'h000, 32'hFFFF_FFFF);
    rd(12'h000, v); chk("R6 only bit0", v, 1);

    // R7 write-only
    wr(12'h60C, 32'hFFFF_FFFF); chk("R7 cal write no err", {31'd0, last_err}, 0);
    wr(12'h614, 32'h1);         chk("R7 ref write no err", {31'd0, last_err}, 0);
    rd(12'h60C, v); chk("R7 cal reads 0", v, 0); chk("R7 cal read err", {31'd0, last_err}, 1);
    rd(12'h004, v); chk("R7 key port reads 0", v, 0); chk("R7 key read err", {31'd0, last_err}, 1);
    rd(12'h100, v); chk("R11 err cleared", {31'd0, acc_err}, 0);

    // R8 read-only
    wr(12'h10C, 32'h0); chk("R8 ro write err", {31'd0, last_err}, 1);
    rd(12'h10C, v);     chk("R8 ro value kept", v, 32'h3F);
    wr(12'h00C, 32'h1); chk("R8 lock status write err", {31'd0, last_err}, 1);
    rd(12'h00C, v);     chk("R8 lock status kept", v, 0);

    // R9 unmapped
    wr(12'h800, 32'hDEAD_BEEF); chk("R9 unmapped write err", {31'd0, last_err}, 1);
    rd(12'h800, v); chk("R9 unmapped reads 0", v, 0); chk("R9 unmapped read err", {31'd0, last_err}, 1);
    wr(12'h7D4, 32'h0000_0A5A);
    rd(12'h7D4, v); chk("R9 last pin mapped", v, 32'h0A5A);
    wr(12'h7D8, 32'h1111_1111); chk("R9 past last pin err", {31'd0, last_err}, 1);
    rd(12'h100, v); chk("R9 no state change", v, 32'hCAFE_F00D);

    // R10 soft reset pulse
    wr(12'h200, 32'h0000_0003);
    chk("R10 pulse", {31'd0, last_rst}, 1);
    chk("R10 single cycle", {31'd0, next_rst}, 0);
    rd(12'h200, v); chk("R10 stored", v, 3);
    wr(12'h200, 32'h0000_0002);
    chk("R10 bit0 clear no pulse", {31'd0, last_rst}, 0);

    // R12 low address bits ignored
    wr(12'h105, 32'h5555_AAAA);
    rd(12'h107, v); chk("R12 low bits ignored", v, 32'h5555_AAAA);

    // R3 engage keys, then locked reset-control write
    wr(12'h004, 32'h0000_767C);
    rd(12'h00C, v); chk("R3 bad engage key ignored", v, 0);
    wr(12'h004, 32'hFFFF_767B);
    rd(12'h00C, v); chk("R3 engaged", v, 1);
    wr(12'h200, 32'h0000_0001);
    chk("R10 locked no pulse", {31'd0, last_rst}, 0);
    rd(12'h200, v); chk("R5 locked reset ctl kept", v, 2);
    wr(12'h008, 32'h0000_DF0D);
    rd(12'h00C, v); chk("R5 release while locked", v, 0);

    // R2 read and write same cycle returns old value
    @(negedge clk); addr = 12'h104; wdata = 32'h0BAD_F00D; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
    chk("R2 same-cycle read old", rd_data, 32'h5555_AAAA);
    rd(12'h104, v); chk("R2 same-cycle write landed", v, 32'h0BAD_F00D);

    repeat (3) @(negedge clk);
    finish_up();
  end
endmodule